// File: doc/BRIEF.md
# Wait-Pin Event Interrupt Controller

This block gathers interrupt causes for an external memory controller into one sticky status register. Two pulses from the controller's NAND engine are recorded at fixed low indices: a FIFO-level event and a terminal-count event. An edge detector on each of `N_WAIT` asynchronous wait inputs records its event at the indices above them. A mask register gates the status into a single interrupt line. Software clears a cause by writing a one to its status bit.

The same wait inputs can also be read back as plain general-purpose levels after synchronisation, so a board can use spare wait lines as inputs. Each pin has a select bit that chooses whether its rising edge or its falling edge raises the event.

Software uses a small register port. Writes take effect on the next clock edge. Read data is a combinational function of the address.

Top module: `wpi_event_ctrl`

## Requirements
- R1: A one-cycle pulse on `fifo_evt_i` sets status bit 0, and a pulse on `tc_evt_i` sets status bit 1. Each bit is visible on the clock edge that samples the pulse.
- R2: An accepted edge on `wait_i[k]` sets status bit 2+k. The bit becomes visible three clock edges after the pin changes: two synchroniser flops, then the edge register.
- R3: Bit k of the edge-select register (address 2) chooses the edge for pin k: 1 = rising, 0 = falling. An edge of the other polarity leaves status unchanged. The register resets to all ones.
- R4: Reading address 3 returns the synchronised pin levels, with bit k equal to `wait_i[k]`, two clock edges after the pin changes. Writes to address 3 have no effect.
- R5: Status bits are sticky. A set bit stays set until software clears it.
- R6: Writing to address 0 clears every status bit whose data bit is one. Bits written as zero are left unchanged.
- R7: If an event and a clear of the same bit fall in the same cycle, the event wins and the bit stays set.
- R8: `irq_o` is high exactly when some status bit and its mask bit (address 1) are both one. The mask does not affect status.
- R9: After reset, status and mask are zero, edge-select is all ones, and `irq_o` is low.
- R10: The mask and edge-select registers read back the written values. Bits above the implemented sources read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 status, 1 mask, 2 edge select, 3 pin level |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for `reg_addr_i` |
| fifo_evt_i | input | 1 | NAND FIFO-level event pulse |
| tc_evt_i | input | 1 | NAND terminal-count event pulse |
| wait_i | input | N_WAIT | Asynchronous wait pins |
| irq_o | output | 1 | Combined interrupt |

## Verification
Each engine pulse is driven on its own and then together with a clear. This shows the two fixed indices are distinct and confirms the set-over-clear priority. The wait pins are toggled on the lowest and highest pins, under both select values and in both directions. This separates a correct polarity choice from both-edge detection or an off-by-one index, and the level reads taken one edge before the status update confirm the synchroniser depth. Masks are applied both fully and partially, which shows that the interrupt follows the status-and-mask product while status itself ignores the mask.

// File: rtl/wpi_pkg.sv
package wpi_pkg;
  typedef enum logic [1:0] {
    REG_STATUS   = 2'd0,
    REG_MASK     = 2'd1,
    REG_EDGE_SEL = 2'd2,
    REG_LEVEL    = 2'd3
  } wpi_reg_e;

  localparam int unsigned ENGINE_SRCS = 2;
endpackage

// File: rtl/wpi_sync.sv
module wpi_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wpi_edge_det.sv
module wpi_edge_det #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_sel_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar k = 0; k < W; k++) begin : g_pin
    logic rise, fall;
    assign rise     = lvl_i[k] & ~prev_q[k];
    assign fall     = ~lvl_i[k] & prev_q[k];
    assign evt_o[k] = rise_sel_i[k] ? rise : fall;
  end
endmodule

// File: rtl/wpi_status.sv
module wpi_status #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] status_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/wpi_event_ctrl.sv
module wpi_event_ctrl
  import wpi_pkg::*;
#(
  parameter int unsigned N_WAIT = 4,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              fifo_evt_i,
  input  logic              tc_evt_i,
  input  logic [N_WAIT-1:0] wait_i,
  output logic              irq_o
);
  localparam int unsigned NSRC = ENGINE_SRCS + N_WAIT;

  wpi_reg_e          addr;
  logic [N_WAIT-1:0] pin_lvl, pin_evt, sel_q;
  logic [NSRC-1:0]   mask_q, status_q, set_vec, clr_vec;
  logic              wr_status, wr_mask, wr_sel;

  assign addr      = wpi_reg_e'(reg_addr_i);
  assign wr_status = reg_we_i && (addr == REG_STATUS);
  assign wr_mask   = reg_we_i && (addr == REG_MASK);
  assign wr_sel    = reg_we_i && (addr == REG_EDGE_SEL);

  wpi_sync #(.W(N_WAIT)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wait_i),
    .q_o   (pin_lvl)
  );

  wpi_edge_det #(.W(N_WAIT)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (pin_lvl),
    .rise_sel_i(sel_q),
    .evt_o     (pin_evt)
  );

  assign set_vec = {pin_evt, tc_evt_i, fifo_evt_i};
  assign clr_vec = wr_status ? reg_wdata_i[NSRC-1:0] : '0;

  wpi_status #(.W(NSRC)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .status_o(status_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      sel_q  <= '1;
    end else begin
      if (wr_mask) mask_q <= reg_wdata_i[NSRC-1:0];
      if (wr_sel)  sel_q  <= reg_wdata_i[N_WAIT-1:0];
    end
  end

  if (DW > NSRC) begin : g_spare
    logic unused_wdata;
    assign unused_wdata = ^reg_wdata_i[DW-1:NSRC];
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      REG_STATUS:   reg_rdata_o[NSRC-1:0]   = status_q;
      REG_MASK:     reg_rdata_o[NSRC-1:0]   = mask_q;
      REG_EDGE_SEL: reg_rdata_o[N_WAIT-1:0] = sel_q;
      REG_LEVEL:    reg_rdata_o[N_WAIT-1:0] = pin_lvl;
      default:      reg_rdata_o             = '0;
    endcase
  end

  assign irq_o = |(status_q & mask_q);
endmodule

// File: rtl/wpi_event_ctrl_chk.sv
module wpi_event_ctrl_chk #(
  parameter int unsigned N_WAIT = 4,
  parameter int unsigned NSRC   = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_status,
  input logic [NSRC-1:0]   clr_vec,
  input logic              fifo_evt_i,
  input logic              tc_evt_i,
  input logic [N_WAIT-1:0] pin_evt,
  input logic [NSRC-1:0]   status_q,
  input logic [NSRC-1:0]   mask_q,
  input logic              irq_o
);
  p_fifo_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_evt_i |=> status_q[0]);

  p_tc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_evt_i |=> status_q[1]);

  for (genvar k = 0; k < N_WAIT; k++) begin : g_pin
    p_pin_evt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_evt[k] |=> status_q[2+k]);
  end

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_status |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && clr_vec[0] && !fifo_evt_i) |=> !status_q[0]);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && clr_vec[1] && tc_evt_i) |=> status_q[1]);

  p_mask_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q == '0) |-> !irq_o);
endmodule

bind wpi_event_ctrl wpi_event_ctrl_chk #(.N_WAIT(N_WAIT), .NSRC(NSRC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_status (wr_status),
  .clr_vec   (clr_vec),
  .fifo_evt_i(fifo_evt_i),
  .tc_evt_i  (tc_evt_i),
  .pin_evt   (pin_evt),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .irq_o     (irq_o)
);

// File: tb/wpi_event_ctrl_tb_top.sv
`timescale 1ns/1ps
module wpi_event_ctrl_tb_top;
  localparam int unsigned N_WAIT = 4;
  localparam int unsigned DW     = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we_i = 1'b0;
  logic [1:0]        reg_addr_i = '0;
  logic [DW-1:0]     reg_wdata_i = '0;
  logic [DW-1:0]     reg_rdata_o;
  logic              fifo_evt_i = 1'b0;
  logic              tc_evt_i = 1'b0;
  logic [N_WAIT-1:0] wait_i = '0;
  logic              irq_o;

  int checks = 0;
  int failures = 0;
  logic rd_stb = 1'b0;
  logic done = 1'b0;

  typedef struct {
    logic [DW-1:0] rdata;
    logic          irq;
    string         tag;
  } exp_t;
  exp_t sb_q[$];
  exp_t cur;

  always #2.5 clk_i = ~clk_i;

  wpi_event_ctrl #(.N_WAIT(N_WAIT), .DW(DW)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .fifo_evt_i (fifo_evt_i),
    .tc_evt_i   (tc_evt_i),
    .wait_i     (wait_i),
    .irq_o      (irq_o)
  );

  // monitor: compare at the falling edge
  always @(negedge clk_i) begin
    if (rd_stb && sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      checks++;
      if (reg_rdata_o !== cur.rdata || irq_o !== cur.irq) begin
        failures++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 cur.tag, reg_rdata_o, irq_o, cur.rdata, cur.irq);
      end
    end
  end

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [DW-1:0] e,
                    input logic ei, input string tag);
    exp_t it;
    it.rdata = e; it.irq = ei; it.tag = tag;
    sb_q.push_back(it);
    reg_addr_i = a; rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0;
  endtask

  task automatic pins(input logic [N_WAIT-1:0] v);
    wait_i = v;
    tick(); tick(); tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    // R9 reset state
    rd(2'd0, 32'h0,  1'b0, "R9 status reset");
    rd(2'd1, 32'h0,  1'b0, "R9 mask reset");
    rd(2'd2, 32'hF,  1'b0, "R9 edge select reset");
    rd(2'd3, 32'h0,  1'b0, "R4 level idle");
    // R1 engine events
    fifo_evt_i = 1'b1; tick(); fifo_evt_i = 1'b0;
    rd(2'd0, 32'h1,  1'b0, "R1 fifo -> bit0, masked R8");
    tc_evt_i = 1'b1; tick(); tc_evt_i = 1'b0;
    rd(2'd0, 32'h3,  1'b0, "R1 tc -> bit1");
    // R6 write-one-to-clear
    wr(2'd0, 32'h1);
    rd(2'd0, 32'h2,  1'b0, "R6 clear bit0 only");
    wr(2'd0, 32'h0);
    rd(2'd0, 32'h2,  1'b0, "R5 R6 zero write keeps bit");
    tick(); tick();
    rd(2'd0, 32'h2,  1'b0, "R5 sticky while idle");
    wr(2'd0, 32'h2);
    rd(2'd0, 32'h0,  1'b0, "R6 clear bit1");
    // R10 mask readback, R8 irq
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h3F, 1'b0, "R10 mask upper bits zero");
    fifo_evt_i = 1'b1; tick(); fifo_evt_i = 1'b0;
    rd(2'd0, 32'h1,  1'b1, "R8 irq with mask");
    wr(2'd0, 32'h1);
    rd(2'd0, 32'h0,  1'b0, "R8 irq drops on clear");
    // R4 level, R2 pin0 rising
    wait_i = 4'b0001; tick(); tick();
    rd(2'd3, 32'h1,  1'b0, "R4 level after two edges");
    rd(2'd0, 32'h4,  1'b1, "R2 pin0 rise -> bit2");
    wr(2'd0, 32'h4);
    // R3 falling ignored while rising selected
    pins(4'b0000);
    rd(2'd0, 32'h0,  1'b0, "R3 falling ignored");
    // R3 pin1 select falling
    wr(2'd2, 32'hD);
    rd(2'd2, 32'hD,  1'b0, "R10 edge select readback");
    pins(4'b0010);
    rd(2'd0, 32'h0,  1'b0, "R3 rising ignored on falling select");
    pins(4'b0000);
    rd(2'd0, 32'h8,  1'b1, "R3 R2 pin1 fall -> bit3");
    wr(2'd0, 32'h8);
    // R2 highest pin
    pins(4'b1000);
    rd(2'd0, 32'h20, 1'b1, "R2 pin3 rise -> bit5");
    rd(2'd3, 32'h8,  1'b1, "R4 level pin3");
    wr(2'd3, 32'hF);
    rd(2'd3, 32'h8,  1'b1, "R4 level write ignored");
    wr(2'd0, 32'h20);
    // R7 set wins over clear
    reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 32'h3;
    fifo_evt_i = 1'b1;
    tick();
    reg_we_i = 1'b0; reg_wdata_i = '0; fifo_evt_i = 1'b0;
    rd(2'd0, 32'h1,  1'b1, "R7 event wins over clear");
    // R8 partial mask
    wr(2'd1, 32'h2);
    rd(2'd0, 32'h1,  1'b0, "R8 unmasked bit only, status kept");
    tc_evt_i = 1'b1; tick(); tc_evt_i = 1'b0;
    rd(2'd0, 32'h3,  1'b1, "R8 masked-in bit raises irq");
    tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule